// File: doc/BRIEF.md
# Weighted-Count Page Frame Replacement Controller

This controller keeps the bookkeeping for a small set of page frames that cache a larger, slow backing store. Each frame holds the virtual page number it currently contains, a valid flag, a dirty flag and an access count. An access arrives as a byte address with a read or write indication. The page number is compared with every resident tag, and the controller answers with a hit or a miss. A hit raises the frame's count by a read weight or a write weight. Writes are given their own weight so that pages that are only read can be made the preferred victims.

On a miss the controller picks a victim frame. An empty frame is taken first. Otherwise it takes the frame with the lowest count. It then drives an external transfer engine through a request/done handshake: first a writeback, if the victim is dirty, then a fill. While the fill is under way it scans the other frames one per cycle and adds up their counts. The new page then starts at the average of those counts, not at zero. Without this, a fresh page would always be the next victim. Once the engine reports completion, the original access is replayed as a hit. The byte data path and the backing-store protocol belong to the engine and are not part of this block.

The control is one state machine with four states. IDLE accepts accesses. It goes to WBACK on a miss with a dirty valid victim, and to FILL on a miss with a clean or empty victim. WBACK holds the writeback request and moves to FILL when done arrives. FILL holds the fill request while the count scan runs, and moves to REPLAY once both the scan and the done are complete. REPLAY installs the weight of the original access and returns to IDLE.

Top module: `frame_evict_ctrl`

## Requirements
- R1: Pages are 512 bytes. The page number is `req_addr[ADDR_W-1:9]`, and the low 9 offset bits play no part in the lookup.
- R2: An access accepted in IDLE that hits gives `rsp_hit`=1 for one cycle on the next cycle, with `hit_frame` set to the matching frame. A read hit adds 1<<11 to that frame's count, and a write hit adds `wr_mult`<<11 and marks the frame dirty.
- R3: A miss gives `rsp_miss`=1 for one cycle on the next cycle. The victim is the lowest-numbered invalid frame if one exists. Otherwise it is the valid frame with the smallest count, and the lowest index wins a tie.
- R4: A dirty valid victim first raises `xfer_req` with `xfer_wb`=1, `xfer_frame`=victim and `xfer_vpn`=the old page. After `xfer_done`, it raises `xfer_req` with `xfer_wb`=0 and `xfer_vpn`=the new page. A clean or empty victim skips the writeback request.
- R5: A filled frame starts at floor(sum of the counts of the other FRAMES-1 frames / (FRAMES-1)), where an empty frame counts as 0. The replayed access then adds its own weight to that value.
- R6: Counts saturate at 2^CNT_W-1 and never wrap.
- R7: `ready` is 0 from the cycle after a miss until the replay completes. Accesses presented while `ready`=0 give no response and change no state. `xfer_req` is never 1 while `ready` is 1.
- R8: After the fill completes, the access is replayed: `rsp_hit`=1 with `hit_frame`=victim, and `ready` returns to 1 in the same cycle.
- R9: `hit_count` and `miss_count` count the hits and misses of accesses accepted in IDLE. Replays are not counted. `stat_clr` zeroes both counters on the next cycle and takes priority over counting.
- R10: After reset all frames are empty with zero counts, `ready`=1, the counters are 0, and no request or response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, taken only while ready |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Virtual byte address |
| wr_mult | input | MULT_W | Write weight multiplier, 1 to 128 |
| ready | output | 1 | Controller idle and accepting accesses |
| rsp_hit | output | 1 | Hit or replay response pulse |
| rsp_miss | output | 1 | Miss response pulse |
| hit_frame | output | IDX_W | Frame that served the access |
| xfer_req | output | 1 | Transfer request to the external engine |
| xfer_wb | output | 1 | 1 = writeback, 0 = fill |
| xfer_frame | output | IDX_W | Frame to transfer |
| xfer_vpn | output | VPN_W | Page number for the transfer |
| xfer_done | input | 1 | One-cycle completion pulse from the engine |
| stat_clr | input | 1 | Clear the event counters |
| hit_count | output | STAT_W | Hits counted |
| miss_count | output | STAT_W | Misses counted |

## Verification
The bench builds the controller with FRAMES=4, ADDR_W=16 and CNT_W=20. With only four frames, every miss after the cold fill evicts a resident page, so the choice of victim, the writebacks of dirty pages and the averaged starting count show up within a few accesses. A 20-bit count saturates after four writes at the largest write weight, so the clamp can be told apart from wrap-around by which frame the next miss evicts.

// File: rtl/frame_evict_pkg.sv
package frame_evict_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WBACK  = 2'd1,
        ST_FILL   = 2'd2,
        ST_REPLAY = 2'd3
    } evict_state_t;
endpackage

// File: rtl/frame_match.sv
module frame_match #(
    parameter int FRAMES = 8,
    parameter int VPN_W  = 15,
    localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [VPN_W-1:0]        vpn,
    input  logic [FRAMES*VPN_W-1:0] tags,
    input  logic [FRAMES-1:0]       valid,
    output logic                    hit_any,
    output logic [IDX_W-1:0]        hit_idx
);
    logic [FRAMES-1:0] hit_vec;

    for (genvar g = 0; g < FRAMES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g*VPN_W +: VPN_W] == vpn);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < FRAMES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // R2
    onehot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/victim_select.sv
module victim_select #(
    parameter int FRAMES = 8,
    parameter int CNT_W  = 24,
    localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FRAMES-1:0]       valid,
    input  logic [FRAMES*CNT_W-1:0] cnts,
    output logic [IDX_W-1:0]        victim
);
    logic             inv_found;
    logic [IDX_W-1:0] inv_idx;
    logic [IDX_W-1:0] low_idx;
    logic [CNT_W-1:0] low_cnt;

    always_comb begin
        inv_found = 1'b0;
        inv_idx   = '0;
        low_idx   = '0;
        low_cnt   = cnts[CNT_W-1:0];
        for (int i = 0; i < FRAMES; i++) begin
            if (!valid[i] && !inv_found) begin
                inv_found = 1'b1;
                inv_idx   = IDX_W'(i);
            end
            if (cnts[i*CNT_W +: CNT_W] < low_cnt) begin
                low_cnt = cnts[i*CNT_W +: CNT_W];
                low_idx = IDX_W'(i);
            end
        end
        victim = inv_found ? inv_idx : low_idx;
    end

    // R3
    empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid) |-> !valid[victim]);
endmodule

// File: rtl/frame_evict_ctrl.sv
module frame_evict_ctrl
    import frame_evict_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int OFS_W    = 9,
    parameter int FRAMES   = 8,
    parameter int CNT_W    = 24,
    parameter int WT_SHIFT = 11,
    parameter int MULT_W   = 8,
    parameter int STAT_W   = 16,
    localparam int VPN_W   = ADDR_W - OFS_W,
    localparam int IDX_W   = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int SCAN_W  = $clog2(FRAMES + 1),
    localparam int SUM_W   = CNT_W + SCAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MULT_W-1:0] wr_mult,
    output logic              ready,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IDX_W-1:0]  hit_frame,
    output logic              xfer_req,
    output logic              xfer_wb,
    output logic [IDX_W-1:0]  xfer_frame,
    output logic [VPN_W-1:0]  xfer_vpn,
    input  logic              xfer_done,
    input  logic              stat_clr,
    output logic [STAT_W-1:0] hit_count,
    output logic [STAT_W-1:0] miss_count
);
    localparam logic [CNT_W-1:0]  RD_WT   = CNT_W'(1) << WT_SHIFT;
    localparam logic [SUM_W-1:0]  DIVISOR = SUM_W'(FRAMES - 1);
    localparam logic [SCAN_W-1:0] SCAN_END = SCAN_W'(FRAMES);

    evict_state_t state_q, state_d;

    logic [VPN_W-1:0]        tag_q [FRAMES];
    logic [CNT_W-1:0]        cnt_q [FRAMES];
    logic [FRAMES-1:0]       val_q, dirty_q;
    logic [FRAMES*VPN_W-1:0] tag_flat;
    logic [FRAMES*CNT_W-1:0] cnt_flat;

    logic [VPN_W-1:0]  vpn_q;
    logic              wr_q;
    logic [IDX_W-1:0]  vic_q;
    logic [SCAN_W-1:0] scan_q;
    logic [SUM_W-1:0]  sum_q;
    logic              done_seen_q;

    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx, vic_w;
    logic [CNT_W-1:0]  wr_wt, avg_w;
    logic              take, scan_done, fill_go;

    for (genvar g = 0; g < FRAMES; g++) begin : g_flat
        assign tag_flat[g*VPN_W +: VPN_W] = tag_q[g];
        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
    end

    frame_match #(.FRAMES(FRAMES), .VPN_W(VPN_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .vpn(req_addr[ADDR_W-1:OFS_W]), .tags(tag_flat), .valid(val_q),
        .hit_any(hit_any), .hit_idx(hit_idx)
    );

    victim_select #(.FRAMES(FRAMES), .CNT_W(CNT_W)) u_vic (
        .clk(clk), .rst_n(rst_n),
        .valid(val_q), .cnts(cnt_flat), .victim(vic_w)
    );

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
    endfunction

    assign wr_wt     = CNT_W'(wr_mult) << WT_SHIFT;
    assign avg_w     = CNT_W'(sum_q / DIVISOR);
    assign take      = (state_q == ST_IDLE) && req_valid;
    assign scan_done = (scan_q == SCAN_END);
    assign fill_go   = (state_q == ST_FILL) && scan_done && (done_seen_q || xfer_done);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take && !hit_any)
                           state_d = (val_q[vic_w] && dirty_q[vic_w]) ? ST_WBACK : ST_FILL;
            ST_WBACK:  if (xfer_done) state_d = ST_FILL;
            ST_FILL:   if (fill_go) state_d = ST_REPLAY;
            ST_REPLAY: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        ready      = (state_q == ST_IDLE);
        xfer_wb    = (state_q == ST_WBACK);
        xfer_req   = (state_q == ST_WBACK) || ((state_q == ST_FILL) && !done_seen_q);
        xfer_frame = vic_q;
        xfer_vpn   = (state_q == ST_WBACK) ? tag_q[vic_q] : vpn_q;
    end

    // frame table, scan and responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FRAMES; i++) begin
                tag_q[i] <= '0;
                cnt_q[i] <= '0;
            end
            val_q       <= '0;
            dirty_q     <= '0;
            vpn_q       <= '0;
            wr_q        <= 1'b0;
            vic_q       <= '0;
            scan_q      <= '0;
            sum_q       <= '0;
            done_seen_q <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            hit_frame   <= '0;
        end else begin
            rsp_hit  <= 1'b0;
            rsp_miss <= 1'b0;
            if (take && hit_any) begin
                rsp_hit        <= 1'b1;
                hit_frame      <= hit_idx;
                cnt_q[hit_idx] <= sat_add(cnt_q[hit_idx], req_write ? wr_wt : RD_WT);
                if (req_write) dirty_q[hit_idx] <= 1'b1;
            end
            if (take && !hit_any) begin
                rsp_miss <= 1'b1;
                vpn_q    <= req_addr[ADDR_W-1:OFS_W];
                wr_q     <= req_write;
                vic_q    <= vic_w;
            end
            if (state_d == ST_FILL && state_q != ST_FILL) begin
                scan_q      <= '0;
                sum_q       <= '0;
                done_seen_q <= 1'b0;
            end
            if (state_q == ST_FILL) begin
                if (xfer_done) done_seen_q <= 1'b1;
                if (!scan_done) begin
                    scan_q <= scan_q + 1'b1;
                    if (scan_q != SCAN_W'(vic_q))
                        sum_q <= sum_q + SUM_W'(cnt_q[scan_q[IDX_W-1:0]]);
                end
            end
            if (fill_go) begin
                tag_q[vic_q]   <= vpn_q;
                cnt_q[vic_q]   <= avg_w;
                val_q[vic_q]   <= 1'b1;
                dirty_q[vic_q] <= 1'b0;
            end
            if (state_q == ST_REPLAY) begin
                rsp_hit      <= 1'b1;
                hit_frame    <= vic_q;
                cnt_q[vic_q] <= sat_add(cnt_q[vic_q], wr_q ? wr_wt : RD_WT);
                if (wr_q) dirty_q[vic_q] <= 1'b1;
            end
        end
    end

    // event counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (stat_clr) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (take) begin
            if (hit_any) hit_count  <= hit_count + 1'b1;
            else         miss_count <= miss_count + 1'b1;
        end
    end

    // R7
    busy_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !ready);

    // R7
    miss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> !ready);

    // R4
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_wb && xfer_done) |=> (xfer_req && !xfer_wb));

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (hit_count == '0 && miss_count == '0));
endmodule

// File: tb/sim_frame_evict_ctrl.sv
module sim_frame_evict_ctrl;
    localparam int AW = 16;
    localparam int F  = 4;
    localparam int CW = 20;
    localparam longint CMAX = (longint'(1) << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] wr_mult = 8'd1;
    logic       ready, rsp_hit, rsp_miss, xfer_req, xfer_wb;
    logic [1:0] hit_frame, xfer_frame;
    logic [6:0] xfer_vpn;
    logic       xfer_done = 1'b0, stat_clr = 1'b0;
    logic [15:0] hit_count, miss_count;

    always #5 clk = ~clk;

    frame_evict_ctrl #(.ADDR_W(AW), .FRAMES(F), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .wr_mult(wr_mult), .ready(ready), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .hit_frame(hit_frame), .xfer_req(xfer_req),
        .xfer_wb(xfer_wb), .xfer_frame(xfer_frame), .xfer_vpn(xfer_vpn),
        .xfer_done(xfer_done), .stat_clr(stat_clr), .hit_count(hit_count),
        .miss_count(miss_count)
    );

    int total = 0, bad = 0;
    bit fin = 1'b0;
    int m_tag [F];
    bit m_val [F];
    bit m_dirty [F];
    longint m_cnt [F];
    int b_hits = 0, b_miss = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic longint wgt(input bit wr);
        return wr ? (longint'(wr_mult) << 11) : (longint'(1) << 11);
    endfunction

    function automatic longint sat(input longint a);
        return (a > CMAX) ? CMAX : a;
    endfunction

    task automatic serve(input bit wb, input int fr, input int vpn, input string rq);
        int n;
        n = 0;
        while (!xfer_req && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(xfer_req == 1'b1, {rq, " request"}, xfer_req, 1);
        chk(xfer_wb == wb, {rq, " kind"}, xfer_wb, wb);
        chk(xfer_frame == fr, {rq, " frame"}, xfer_frame, fr);
        chk(xfer_vpn == vpn, {rq, " page"}, xfer_vpn, vpn);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic do_access(input bit wr, input int addr, input bit poke, input string lbl);
        int vpn, h, v, n;
        longint sum, lowc;
        vpn = (addr >> 9) & 8'h7f;
        h = -1;
        for (int i = 0; i < F; i++) if (m_val[i] && m_tag[i] == vpn) h = i;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        if (h >= 0) begin
            b_hits++;
            chk(rsp_hit == 1'b1 && rsp_miss == 1'b0, {lbl, " R2 hit flag"}, rsp_hit, 1);
            chk(hit_frame == h, {lbl, " R2 hit frame"}, hit_frame, h);
            m_cnt[h] = sat(m_cnt[h] + wgt(wr));
            if (wr) m_dirty[h] = 1'b1;
        end else begin
            b_miss++;
            chk(rsp_miss == 1'b1 && rsp_hit == 1'b0, {lbl, " R3 miss flag"}, rsp_miss, 1);
            v = -1;
            for (int i = 0; i < F; i++) if (!m_val[i] && v < 0) v = i;
            if (v < 0) begin
                v = 0;
                lowc = m_cnt[0];
                for (int i = 1; i < F; i++) if (m_cnt[i] < lowc) begin
                    lowc = m_cnt[i];
                    v = i;
                end
            end
            if (poke) begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = AW'(addr);
                @(negedge clk);
                req_valid = 1'b0;
                chk(rsp_hit == 1'b0 && ready == 1'b0, {lbl, " R7 access ignored while busy"}, rsp_hit, 0);
            end
            if (m_val[v] && m_dirty[v]) serve(1'b1, v, m_tag[v], {lbl, " R4 writeback"});
            serve(1'b0, v, vpn, {lbl, " R3/R4 fill"});
            sum = 0;
            for (int i = 0; i < F; i++) if (i != v) sum += m_cnt[i];
            m_tag[v]   = vpn;
            m_val[v]   = 1'b1;
            m_dirty[v] = wr;
            m_cnt[v]   = sat(sum / (F - 1) + wgt(wr));
            n = 0;
            while (!rsp_hit && n < 60) begin
                @(negedge clk);
                n++;
            end
            chk(rsp_hit == 1'b1, {lbl, " R8 replay response"}, rsp_hit, 1);
            chk(hit_frame == v, {lbl, " R8 replay frame"}, hit_frame, v);
            chk(ready == 1'b1, {lbl, " R7 ready after replay"}, ready, 1);
        end
    endtask

    task automatic t_reset();
        chk(ready == 1'b1, "R10 ready", ready, 1);
        chk(rsp_hit == 1'b0 && rsp_miss == 1'b0, "R10 no response", rsp_hit, 0);
        chk(xfer_req == 1'b0, "R10 no request", xfer_req, 0);
        chk(hit_count == 0 && miss_count == 0, "R10 counters", hit_count, 0);
    endtask

    task automatic t_cold_fill();
        do_access(1'b0, 16'h0400, 1'b0, "R3 cold p2");
        do_access(1'b0, 16'h0a00, 1'b0, "R3 cold p5");
        do_access(1'b1, 16'h1000, 1'b0, "R3 cold p8");
        do_access(1'b0, 16'h2200, 1'b0, "R3 cold p17");
    endtask

    task automatic t_offset();
        do_access(1'b0, 16'h05ff, 1'b0, "R1 offset top");
        do_access(1'b0, 16'h0a37, 1'b0, "R1 offset mid");
    endtask

    task automatic t_weights();
        wr_mult = 8'd64;
        do_access(1'b1, 16'h0a10, 1'b0, "R2 write weight");
        wr_mult = 8'd1;
        do_access(1'b0, 16'h2204, 1'b0, "R2 read weight");
        do_access(1'b0, 16'h3000, 1'b0, "R3 least used victim");
    endtask

    task automatic t_dirty();
        do_access(1'b0, 16'h4000, 1'b0, "R4 clean or dirty victim");
        do_access(1'b0, 16'h4200, 1'b0, "R4 next victim");
    endtask

    task automatic t_average();
        for (int k = 0; k < 3; k++) do_access(1'b0, 16'h4000, 1'b0, "R5 boost");
        do_access(1'b0, 16'h5000, 1'b0, "R5 averaged install");
        do_access(1'b0, 16'h5200, 1'b0, "R5 new page not reused");
    endtask

    task automatic t_sat();
        wr_mult = 8'd128;
        for (int k = 0; k < 5; k++) do_access(1'b1, 16'h5004, 1'b0, "R6 saturate");
        do_access(1'b1, 16'h4000, 1'b0, "R6 lift other");
        do_access(1'b1, 16'h4000, 1'b0, "R6 lift other");
        wr_mult = 8'd1;
        do_access(1'b0, 16'h6000, 1'b0, "R6 saturated frame kept");
    endtask

    task automatic t_busy();
        do_access(1'b0, 16'h7000, 1'b1, "R7 busy");
        do_access(1'b1, 16'h7200, 1'b1, "R7 busy");
    endtask

    task automatic t_stats();
        @(negedge clk);
        chk(hit_count == b_hits, "R9 hit count", hit_count, b_hits);
        chk(miss_count == b_miss, "R9 miss count", miss_count, b_miss);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        chk(hit_count == 0 && miss_count == 0, "R9 clear", hit_count, 0);
        b_hits = 0;
        b_miss = 0;
        do_access(1'b0, 16'h7000, 1'b0, "R9 after clear");
        @(negedge clk);
        chk(hit_count == b_hits && miss_count == b_miss, "R9 recount",
            hit_count + miss_count, b_hits + b_miss);
    endtask

    initial begin
        for (int i = 0; i < F; i++) begin
            m_tag[i] = 0;
            m_val[i] = 1'b0;
            m_dirty[i] = 1'b0;
            m_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_fill();
        t_offset();
        t_weights();
        t_dirty();
        t_average();
        t_sat();
        t_busy();
        t_stats();
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule